// File: doc/BRIEF.md
# Trip and Trap Handler Entry Unit

This block performs the hardware side of entering an interrupt handler. It handles two classes of entry. A trip sends control to a handler inside the user program. A trap sends control to a handler in the operating system. When an entry is granted, the block captures four values into a save set owned by that class:

- the address of the instruction after the interrupted one,
- the interrupted instruction word,
- the instruction's two operands.

In the same clock edge it moves general register 255 into the class's bootstrap register and loads register 255 from the return-jump register. It also emits the class's handler vector as the new program counter.

The block holds these registers itself:

- register 255,
- the return-jump register,
- the two vector registers,
- both save sets.

All of them can be read and written through one indexed access port. Deciding which event fires belongs to the surrounding pipeline, and so do the resume instructions. The pipeline drives a trip or trap request line, together with the instruction word, its operands and the next address.

Top module: `trip_trap_entry`

## Requirements
- R1: After reset, every register readable at the access port reads zero and `new_pc_vld` is low.
- R2: Index map of `sr_idx` (4 bits):
  - 0 = register 255, 1 = return-jump register, 2 = trip vector, 3 = trap vector;
  - 4..8 = trip set (bootstrap, next address, instruction, operand Y, operand Z);
  - 9..13 = trap set, same order;
  - 14 and 15 always read zero and ignore writes.
  A write at an index is returned by `sr_rdata` from the next cycle.
- R3: A granted trip stores the following into indices 5..8, and leaves indices 9..13 unchanged:
  - `req_next`,
  - `req_insn` zero-extended (upper bits zero),
  - `req_opy`,
  - `req_opz`.
- R4: A granted trap stores the same four values into indices 10..13 and leaves indices 4..8 unchanged.
- R5: On a granted entry, the bootstrap register of that class (index 4 for a trip, 9 for a trap) receives the old register 255. Register 255 receives the return-jump register, which itself is unchanged.
- R6: `new_pc_vld` is high in exactly the one cycle after a granted request. During that cycle `new_pc` equals the trip vector (index 2) or the trap vector (index 3) as held in the request cycle.
- R7: When `trip_req` and `trap_req` are both high, only the trap is granted. The trip stays ungranted until it is requested alone.
- R8: `trip_ack`/`trap_ack` report the grant combinationally in the request cycle, and at most one is high.
- R9: An access-port write in a cycle with a granted entry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_req | input | 1 | Request a user-level handler entry |
| trap_req | input | 1 | Request a system-level handler entry |
| req_insn | input | INSN_W | Interrupted instruction word |
| req_opy | input | DATA_W | Y operand of the interrupted instruction |
| req_opz | input | DATA_W | Z operand of the interrupted instruction |
| req_next | input | DATA_W | Address of the following instruction |
| trip_ack | output | 1 | Trip granted this cycle |
| trap_ack | output | 1 | Trap granted this cycle |
| sr_wr_en | input | 1 | Access-port write enable |
| sr_idx | input | 4 | Access-port register index |
| sr_wdata | input | DATA_W | Access-port write data |
| sr_rdata | output | DATA_W | Access-port read data |
| new_pc | output | DATA_W | Handler vector address |
| new_pc_vld | output | 1 | `new_pc` is valid |

## Verification
The assertions check every cycle that:
- the grants are exclusive and give the trap priority;
- a valid new PC follows exactly the cycles with a grant;
- the new PC carries the vector of the granted class;
- register 255 takes the old return-jump value on every entry.

Only the bench scenarios can show the following, because they need the complete register picture read back through the access port:
- that the save sets hold the right payload, zero-extended;
- that the other class's set is untouched;
- that a write colliding with an entry is dropped;
- that the unused indices stay zero.

// File: rtl/trip_trap_pkg.sv
package trip_trap_pkg;
   localparam int IDX_W    = 4;
   localparam int NUM_IDX  = 1 << IDX_W;
   localparam int SET_LEN  = 5;
   localparam int NUM_SETS = 2;

   typedef enum logic [IDX_W-1:0] {
      IX_G255  = 4'd0,
      IX_RJMP  = 4'd1,
      IX_TVEC  = 4'd2,
      IX_TTVEC = 4'd3
   } core_idx_e;

   localparam int SET_BASE0 = 4;

   localparam int SL_BOOT = 0;
   localparam int SL_NEXT = 1;
   localparam int SL_INSN = 2;
   localparam int SL_OPY  = 3;
   localparam int SL_OPZ  = 4;
endpackage

// File: rtl/entry_arb.sv
module entry_arb (
   input  logic trip_req,
   input  logic trap_req,
   output logic trip_go,
   output logic trap_go,
   output logic any_go
);
   // System-level entries win; a user-level entry waits for a free cycle.
   always_comb begin
      trap_go = trap_req;
      trip_go = trip_req & ~trap_req;
      any_go  = trip_go | trap_go;
   end
endmodule

// File: rtl/save_bank.sv
module save_bank #(
   parameter int DATA_W = 64,
   parameter int INSN_W = 32,
   parameter int BASE   = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             enter,
   input  logic                             busy,
   input  logic [DATA_W-1:0]                boot_in,
   input  logic [INSN_W-1:0]                insn,
   input  logic [DATA_W-1:0]                opy,
   input  logic [DATA_W-1:0]                opz,
   input  logic [DATA_W-1:0]                nxt,
   input  logic                             wr_en,
   input  logic [trip_trap_pkg::IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0]                wr_data,
   output logic [DATA_W-1:0]                slot [trip_trap_pkg::SET_LEN]
);
   import trip_trap_pkg::*;

   localparam int LAST = BASE + SET_LEN - 1;

   int  rel;
   logic hit;

   always_comb begin
      rel = int'(wr_idx) - BASE;
      hit = wr_en && !busy && (int'(wr_idx) >= BASE) && (int'(wr_idx) <= LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < SET_LEN; k++) slot[k] <= '0;
      end else if (enter) begin
         slot[SL_BOOT] <= boot_in;
         slot[SL_NEXT] <= nxt;
         slot[SL_INSN] <= DATA_W'(insn);
         slot[SL_OPY]  <= opy;
         slot[SL_OPZ]  <= opz;
      end else if (hit) begin
         for (int k = 0; k < SET_LEN; k++)
            if (rel == k) slot[k] <= wr_data;
      end
   end
endmodule

// File: rtl/trip_trap_entry.sv
module trip_trap_entry #(
   parameter int DATA_W = 64,
   parameter int INSN_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            trip_req,
   input  logic                            trap_req,
   input  logic [INSN_W-1:0]               req_insn,
   input  logic [DATA_W-1:0]               req_opy,
   input  logic [DATA_W-1:0]               req_opz,
   input  logic [DATA_W-1:0]               req_next,
   output logic                            trip_ack,
   output logic                            trap_ack,
   input  logic                            sr_wr_en,
   input  logic [trip_trap_pkg::IDX_W-1:0] sr_idx,
   input  logic [DATA_W-1:0]               sr_wdata,
   output logic [DATA_W-1:0]               sr_rdata,
   output logic [DATA_W-1:0]               new_pc,
   output logic                            new_pc_vld
);
   import trip_trap_pkg::*;

   generate
      if (INSN_W > DATA_W) begin : g_bad_w
         $error("INSN_W must not exceed DATA_W");
      end
      if (SET_BASE0 + NUM_SETS*SET_LEN > NUM_IDX) begin : g_bad_map
         $error("register map does not fit the index width");
      end
   endgenerate

   logic trip_go, trap_go, any_go;
   logic [DATA_W-1:0] g255_q, rj_q, tvec_q, ttvec_q;
   logic [DATA_W-1:0] view [NUM_IDX];
   logic              core_wr;

   entry_arb u_arb (
      .trip_req (trip_req),
      .trap_req (trap_req),
      .trip_go  (trip_go),
      .trap_go  (trap_go),
      .any_go   (any_go)
   );

   assign trip_ack = trip_go;
   assign trap_ack = trap_go;
   assign core_wr  = sr_wr_en && !any_go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         g255_q  <= '0;
         rj_q    <= '0;
         tvec_q  <= '0;
         ttvec_q <= '0;
      end else begin
         if (any_go)                           g255_q  <= rj_q;
         else if (core_wr && sr_idx == IX_G255) g255_q  <= sr_wdata;
         if (core_wr && sr_idx == IX_RJMP)     rj_q    <= sr_wdata;
         if (core_wr && sr_idx == IX_TVEC)     tvec_q  <= sr_wdata;
         if (core_wr && sr_idx == IX_TTVEC)    ttvec_q <= sr_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         new_pc     <= '0;
         new_pc_vld <= 1'b0;
      end else begin
         new_pc_vld <= any_go;
         if (any_go) new_pc <= trap_go ? ttvec_q : tvec_q;
      end
   end

   assign view[IX_G255]  = g255_q;
   assign view[IX_RJMP]  = rj_q;
   assign view[IX_TVEC]  = tvec_q;
   assign view[IX_TTVEC] = ttvec_q;

   generate
      for (genvar c = 0; c < NUM_SETS; c++) begin : g_set
         localparam int BASE = SET_BASE0 + c*SET_LEN;
         logic [DATA_W-1:0] slot [SET_LEN];
         logic              enter;
         assign enter = (c == 0) ? trip_go : trap_go;

         save_bank #(.DATA_W(DATA_W), .INSN_W(INSN_W), .BASE(BASE)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .enter   (enter),
            .busy    (any_go),
            .boot_in (g255_q),
            .insn    (req_insn),
            .opy     (req_opy),
            .opz     (req_opz),
            .nxt     (req_next),
            .wr_en   (sr_wr_en),
            .wr_idx  (sr_idx),
            .wr_data (sr_wdata),
            .slot    (slot)
         );
         for (genvar k = 0; k < SET_LEN; k++) begin : g_view
            assign view[BASE+k] = slot[k];
         end
      end
      for (genvar u = SET_BASE0 + NUM_SETS*SET_LEN; u < NUM_IDX; u++) begin : g_unused
         assign view[u] = '0;
      end
   endgenerate

   assign sr_rdata = view[sr_idx];
endmodule

// File: rtl/trip_trap_entry_chk.sv
module trip_trap_entry_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trip_req,
   input logic              trap_req,
   input logic              trip_ack,
   input logic              trap_ack,
   input logic              new_pc_vld,
   input logic [DATA_W-1:0] new_pc,
   input logic [DATA_W-1:0] g255_q,
   input logic [DATA_W-1:0] rj_q,
   input logic [DATA_W-1:0] tvec_q,
   input logic [DATA_W-1:0] ttvec_q
);
   p_ack_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trip_ack, trap_ack}));

   p_ack_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_ack |-> trip_req) and (trap_ack |-> trap_req));

   p_trap_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_req && trap_req) |-> (trap_ack && !trip_ack));

   p_vld_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_ack || trap_ack) |=> new_pc_vld);

   p_vld_only_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(trip_ack || trap_ack) |=> !new_pc_vld);

   p_trip_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trip_ack |=> new_pc == $past(tvec_q));

   p_trap_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_ack |=> new_pc == $past(ttvec_q));

   p_g255_gets_j_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_ack || trap_ack) |=> g255_q == $past(rj_q));

   p_j_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_ack || trap_ack) |=> $stable(rj_q));
endmodule

bind trip_trap_entry trip_trap_entry_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trip_req   (trip_req),
   .trap_req   (trap_req),
   .trip_ack   (trip_ack),
   .trap_ack   (trap_ack),
   .new_pc_vld (new_pc_vld),
   .new_pc     (new_pc),
   .g255_q     (g255_q),
   .rj_q       (rj_q),
   .tvec_q     (tvec_q),
   .ttvec_q    (ttvec_q)
);

// File: tb/trip_trap_entry_test.sv
module trip_trap_entry_test;
   localparam int DW = 64;
   localparam int IW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trip_req = 1'b0, trap_req = 1'b0;
   logic [IW-1:0] req_insn = '0;
   logic [DW-1:0] req_opy = '0, req_opz = '0, req_next = '0;
   logic          trip_ack, trap_ack;
   logic          sr_wr_en = 1'b0;
   logic [3:0]    sr_idx = '0;
   logic [DW-1:0] sr_wdata = '0;
   logic [DW-1:0] sr_rdata, new_pc;
   logic          new_pc_vld;

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] mdl [16];

   always #5 clk = ~clk;

   trip_trap_entry #(.DATA_W(DW), .INSN_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .trip_req(trip_req), .trap_req(trap_req),
      .req_insn(req_insn), .req_opy(req_opy), .req_opz(req_opz), .req_next(req_next),
      .trip_ack(trip_ack), .trap_ack(trap_ack), .sr_wr_en(sr_wr_en), .sr_idx(sr_idx),
      .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .new_pc(new_pc), .new_pc_vld(new_pc_vld)
   );

   task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] want);
      n_chk++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, want);
      end
   endtask

   task automatic read_all(input string tag);
      for (int i = 0; i < 16; i++) begin
         sr_idx = 4'(i);
         #1;
         chk($sformatf("%s idx%0d", tag, i), sr_rdata, mdl[i]);
      end
   endtask

   task automatic wr(input int idx, input logic [DW-1:0] d);
      @(negedge clk);
      sr_wr_en = 1'b1; sr_idx = 4'(idx); sr_wdata = d;
      @(negedge clk);
      sr_wr_en = 1'b0;
      if (idx < 14) mdl[idx] = d;
   endtask

   task automatic enter(input bit tr, input bit tp, input logic [IW-1:0] ins,
                        input logic [DW-1:0] y, input logic [DW-1:0] z,
                        input logic [DW-1:0] nx, input bit w, input int widx,
                        input logic [DW-1:0] wd);
      int base;
      logic [DW-1:0] pc_exp;
      bit go;
      @(negedge clk);
      trip_req = tr; trap_req = tp; req_insn = ins; req_opy = y; req_opz = z; req_next = nx;
      sr_wr_en = w; sr_idx = 4'(widx); sr_wdata = wd;
      #1;
      chk("R8 trap_ack", DW'(trap_ack), DW'(tp));
      chk("R7/R8 trip_ack", DW'(trip_ack), DW'(tr & ~tp));
      go = tr | tp;
      base = tp ? 9 : 4;
      pc_exp = tp ? mdl[3] : mdl[2];
      @(negedge clk);
      trip_req = 1'b0; trap_req = 1'b0; sr_wr_en = 1'b0;
      chk("R6 vld after grant", DW'(new_pc_vld), DW'(go));
      if (go) begin
         chk("R6 new_pc", new_pc, pc_exp);
         mdl[base]   = mdl[0];
         mdl[0]      = mdl[1];
         mdl[base+1] = nx;
         mdl[base+2] = DW'(ins);
         mdl[base+3] = y;
         mdl[base+4] = z;
      end else if (w && widx < 14) mdl[widx] = wd;
      @(negedge clk);
      chk("R6 vld one cycle", DW'(new_pc_vld), 0);
      read_all(tp ? "R4/R5 trap state" : "R3/R5 trip state");
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 vld reset", DW'(new_pc_vld), 0);
      read_all("R1 reset");

      // R2: sweep every index, including the two unused ones
      for (int i = 0; i < 16; i++) wr(i, 64'h0123_4567_89AB_0000 + DW'(i * 37));
      read_all("R2 map");

      // R3/R4/R5/R6: alternating entries, values derived arithmetically
      for (int k = 0; k < 8; k++) begin
         wr(1, 64'hA000_0000_0000_0000 + DW'(k));
         wr(0, 64'h5500_0000_0000_0000 + DW'(k * 3));
         wr(2, 64'h0000_0000_0001_0000 + DW'(k * 16));
         wr(3, 64'h0000_0000_0002_0000 + DW'(k * 32));
         enter(k[0] == 1'b0, k[0] == 1'b1, 32'hFEDC_BA98 ^ IW'(k * 4097),
               64'h1111_0000_0000_0000 | DW'(k), 64'h2222_0000_0000_0000 | DW'(k),
               64'h0000_0000_0000_1004 + DW'(k * 4), 1'b0, 0, '0);
      end

      // R7: both requested, trap wins, trip then retried alone
      wr(1, 64'hDEAD_BEEF_0000_0001);
      enter(1'b1, 1'b1, 32'h8000_0001, 64'h77, 64'h88, 64'h2000, 1'b0, 0, '0);
      enter(1'b1, 1'b0, 32'h8000_0002, 64'h99, 64'hAA, 64'h3000, 1'b0, 0, '0);

      // R9: colliding writes dropped
      enter(1'b0, 1'b1, 32'h0000_00FF, 64'h1, 64'h2, 64'h4000, 1'b1, 0, 64'hBAD0_BAD0);
      enter(1'b1, 1'b0, 32'h0000_0F0F, 64'h3, 64'h4, 64'h5000, 1'b1, 1, 64'hBAD1_BAD1);
      enter(1'b0, 1'b1, 32'h0000_1234, 64'h5, 64'h6, 64'h6000, 1'b1, 6, 64'hBAD2_BAD2);

      // R2: no request, plain write still lands
      enter(1'b0, 1'b0, 32'h0, 64'h0, 64'h0, 64'h0, 1'b1, 3, 64'h0000_0000_0009_0000);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule